// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block is the hazard control for a five-stage in-order pipeline whose branches are decided in the decode stage. Each cycle it looks at the instruction sitting in execute and the one sitting in decode. If the execute instruction is a load whose destination register is read by the decode instruction, the loaded value cannot be forwarded in time. The block then holds the program counter and the fetch/decode register for one cycle and zeroes the control bits entering the decode/execute register. This injects one empty slot (a bubble) into the pipeline.

The pipeline predicts branches as not taken. When decode reports a taken branch, the block clears the fetch/decode register, so the wrongly fetched instruction becomes an all-zero no-op. This costs one cycle. A load-use stall outranks a taken branch in the same cycle. In that case the branch stays in decode, and its outcome is evaluated again on the next cycle. All outputs are combinational functions of the current inputs.

Top module: `hazard_ctrl`

## Requirements
- R1: When `ex_is_load` is 1 and `ex_dst_reg` equals `dec_src_a`, a stall is raised: `pc_we`=0, `fd_we`=0, `bubble`=1.
- R2: When `ex_is_load` is 1 and `ex_dst_reg` equals `dec_src_b`, a stall is raised in the same way as in R1.
- R3: When `ex_is_load` is 0, no stall is raised, whatever the register numbers are.
- R4: When `ex_is_load` is 1 but `ex_dst_reg` matches neither decode source, no stall is raised.
- R5: During a stall, `pc_we` and `fd_we` are both 0, so the same instruction is fetched again on the next cycle.
- R6: During a stall, `bubble` is 1, which forces every control bit written into the decode/execute register to zero.
- R7: When `dec_br_taken` is 1 and there is no stall:
  - `fd_flush`=1, which loads the all-zero no-op word into the fetch/decode register;
  - `pc_we`=1 and `fd_we`=1;
  - `bubble`=0, so the branch itself proceeds.
- R8: When a stall and `dec_br_taken` occur in the same cycle, the stall wins: `fd_flush`=0, `pc_we`=0, `fd_we`=0, `bubble`=1.
- R9: With no stall and no taken branch, the outputs are idle: `pc_we`=1, `fd_we`=1, `fd_flush`=0, `bubble`=0.
- R10: A load-use hazard costs exactly one stall cycle. Once the bubble has moved into execute (`ex_is_load`=0), the same decode instruction proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| ex_dst_reg | input | 5 | Destination register of the execute-stage instruction |
| dec_src_a | input | 5 | First source register of the decode-stage instruction |
| dec_src_b | input | 5 | Second source register of the decode-stage instruction |
| dec_br_taken | input | 1 | Branch in decode resolved as taken |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| fd_flush | output | 1 | Load a zero no-op into the fetch/decode register |
| bubble | output | 1 | Zero the control bits entering decode/execute |

## Verification
The bench drives directed patterns that separate the cases from one another:
- a match on each source alone (R1, R2);
- a match with the load flag low, to show that the flag gates the stall (R3);
- a load with no match (R4);
- a taken branch alone (R7);
- a taken branch together with a stall, to show the priority (R8).

A two-cycle load-use sequence shows that the stall lasts one cycle and then releases. A long pseudo-random run over a small register range produces many mixed matches. In every cycle, each output is compared against a behavioural model.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  parameter int REG_W = 5;

  typedef struct packed {
    logic pc_we;
    logic fd_we;
    logic fd_flush;
    logic bubble;
  } hz_ctrl_t;
endpackage

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_W     = hazard_pkg::REG_W,
  parameter bit SKIP_ZERO = 1'b0
) (
  input  logic             is_load,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             stall
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic hit_a, hit_b, dst_ok;

  assign hit_a = (dst == src_a);
  assign hit_b = (dst == src_b);

  generate
    if (SKIP_ZERO) begin : g_skip_zero
      assign dst_ok = (dst != ZERO_REG);
    end else begin : g_all_regs
      assign dst_ok = 1'b1;
    end
  endgenerate

  assign stall = is_load && dst_ok && (hit_a || hit_b);

  always_comb begin
    // R3
    no_load_no_stall_chk: assert (is_load || !stall);
  end
endmodule

// File: rtl/branch_flush_ctrl.sv
module branch_flush_ctrl (
  input  logic br_taken,
  input  logic stall,
  output logic flush
);
  // A stall keeps the branch in decode; its outcome is used again next cycle.
  assign flush = br_taken && !stall;

  always_comb begin
    // R8
    flush_yields_chk: assert (!(flush && stall));
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_W     = hazard_pkg::REG_W,
  parameter bit SKIP_ZERO = 1'b0
) (
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dst_reg,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_br_taken,
  output logic             pc_we,
  output logic             fd_we,
  output logic             fd_flush,
  output logic             bubble
);
  import hazard_pkg::*;

  logic     stall_w;
  logic     flush_w;
  hz_ctrl_t ctl;

  load_use_detect #(.REG_W(REG_W), .SKIP_ZERO(SKIP_ZERO)) u_detect (
    .is_load (ex_is_load),
    .dst     (ex_dst_reg),
    .src_a   (dec_src_a),
    .src_b   (dec_src_b),
    .stall   (stall_w)
  );

  branch_flush_ctrl u_flush (
    .br_taken (dec_br_taken),
    .stall    (stall_w),
    .flush    (flush_w)
  );

  always_comb begin
    ctl          = '0;
    ctl.pc_we    = !stall_w;
    ctl.fd_we    = !stall_w;
    ctl.fd_flush = flush_w;
    ctl.bubble   = stall_w;
  end

  assign pc_we    = ctl.pc_we;
  assign fd_we    = ctl.fd_we;
  assign fd_flush = ctl.fd_flush;
  assign bubble   = ctl.bubble;

  always_comb begin
    // R1
    src_a_freeze_chk: assert (!(ex_is_load && ex_dst_reg == dec_src_a && !SKIP_ZERO) || (!pc_we && !fd_we));
    // R6
    bubble_on_hazard_chk: assert (!(ex_is_load && (ex_dst_reg == dec_src_b) && !SKIP_ZERO) || bubble);
    // R7
    branch_flush_chk: assert (!(dec_br_taken && !ex_is_load) || (fd_flush && pc_we));
    // R8
    flush_not_bubble_chk: assert (!(fd_flush && bubble));
  end
endmodule

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ex_is_load = 1'b0;
  logic [4:0] ex_dst_reg = '0;
  logic [4:0] dec_src_a = '0;
  logic [4:0] dec_src_b = '0;
  logic       dec_br_taken = 1'b0;
  logic       pc_we, fd_we, fd_flush, bubble;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hazard_ctrl i_hazard_ctrl (
    .ex_is_load   (ex_is_load),
    .ex_dst_reg   (ex_dst_reg),
    .dec_src_a    (dec_src_a),
    .dec_src_b    (dec_src_b),
    .dec_br_taken (dec_br_taken),
    .pc_we        (pc_we),
    .fd_we        (fd_we),
    .fd_flush     (fd_flush),
    .bubble       (bubble)
  );

  task automatic check1(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  // Behavioural model: expectations follow the requirement text.
  task automatic compare(input string tag);
    int hazard, e_pc, e_fd, e_fl, e_bu;
    hazard = 0;
    if (ex_is_load === 1'b1) begin
      if (int'(ex_dst_reg) == int'(dec_src_a)) hazard = 1;
      if (int'(ex_dst_reg) == int'(dec_src_b)) hazard = 1;
    end
    e_pc = hazard ? 0 : 1;
    e_fd = e_pc;
    e_bu = hazard;
    e_fl = (dec_br_taken && hazard == 0) ? 1 : 0;
    check1(tag, "pc_we",    int'(pc_we),    e_pc);
    check1(tag, "fd_we",    int'(fd_we),    e_fd);
    check1(tag, "fd_flush", int'(fd_flush), e_fl);
    check1(tag, "bubble",   int'(bubble),   e_bu);
  endtask

  // Inputs change just after a rising edge; outputs are sampled at the falling edge.
  task automatic step(input string tag, input bit ld, input int d, input int a,
                      input int b, input bit br);
    @(posedge clk);
    #1;
    ex_is_load   = ld;
    ex_dst_reg   = 5'(d);
    dec_src_a    = 5'(a);
    dec_src_b    = 5'(b);
    dec_br_taken = br;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: idle outputs after reset with quiet inputs
    compare("R9");
    check1("R9", "pc_we_reset", int'(pc_we), 1);

    step("R1", 1, 7, 7, 3, 0);
    check1("R5", "pc_hold", int'(pc_we), 0);
    step("R2", 1, 9, 4, 9, 0);
    check1("R6", "bubble_set", int'(bubble), 1);
    step("R3", 0, 7, 7, 7, 0);
    step("R4", 1, 12, 3, 4, 0);
    step("R7", 0, 1, 2, 3, 1);
    check1("R7", "flush_set", int'(fd_flush), 1);
    step("R8", 1, 5, 5, 0, 1);
    check1("R8", "flush_held", int'(fd_flush), 0);
    step("R7", 0, 0, 5, 0, 1);
    step("R1", 1, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0);

    // R10: load then dependent; next cycle the bubble sits in execute
    step("R10", 1, 6, 6, 2, 0);
    step("R10", 0, 0, 6, 2, 0);
    check1("R10", "released", int'(pc_we), 1);

    for (int n = 0; n < 400; n++) begin
      int r = $urandom;
      bit ld = r[0];
      bit br = r[1];
      int d = (r >> 2) & 3;
      int a = (r >> 4) & 3;
      int b = (r >> 6) & 3;
      string tg;
      if (ld && (d == a || d == b)) tg = br ? "R8" : "R5";
      else tg = br ? "R7" : "R9";
      step(tg, ld, d, a, b, br);
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done || cycles > 100000) begin
      if (!done) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule